// File: doc/BRIEF.md
# Pipelined Binary-to-BCD Converter (Radix-1000 Reduction)

This block turns an unsigned binary integer of up to 34 bits, no larger than 9999800001 (the square of 99999), into ten packed BCD digits. It sits behind a binary multiplier that works on operands already converted from BCD, and it returns the product to decimal form. A result can be taken every clock cycle.

The conversion does not run a shift-and-add-3 network across the whole word. Instead it uses the identity 1024 = 1000 + 24. Every bit above position 9 is worth a multiple of 1000 plus a remainder of 24 per unit. A chain of fold stages therefore shrinks the residual by roughly five bits each time, and carries the multiple-of-1000 part forward into an accumulator. Once the residual fits in 20 bits, an exact divide-by-1000 slice produces one radix-1000 digit. The digits come out least significant first, in Horner order, and end up as d3 (0..9) and d2, d1, d0 (each 0..999). Each 10-bit digit is then expanded into three BCD nibbles by a small add-3 network.

The pipeline has eight register stages. No stage holds more than one fold or one divide slice.

Top module: `b1k_bin2bcd`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `bcd_vld` = 0 and `bcd_val` = 0.
- R2: For every input in 0..9999800001, nibble `bcd_val[4*i+3:4*i]` equals decimal digit i of the input, with i = 0 the units digit and i = 9 the 10^9 digit.
- R3: An input sampled with `bin_vld` high at rising edge k appears with `bcd_vld` high right after rising edge k+7 (eight register stages), and only for that one cycle unless the next input was also valid.
- R4: Inputs presented on consecutive cycles give results on consecutive cycles, in the same order, with no stall.
- R5: Cycles with `bin_vld` low produce no result: the number of `bcd_vld` pulses equals the number of accepted inputs.
- R6: Whenever `bcd_vld` is high, every nibble of `bcd_val` is in 0..9, the top nibble included.
- R7: The largest legal input, 9999800001, converts to the nibble pattern 9,9,9,9,8,0,0,0,0,1 (most significant first).
- R8: Values on either side of a radix-1000 digit boundary (999/1000, 999999/1000000, 999999999/1000000000) convert exactly.
- R9: A reset applied while conversions are in flight discards them. No `bcd_vld` pulse follows the reset until a new input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bin_vld | input | 1 | Marks `bin_val` as a value to convert this cycle |
| bin_val | input | 34 | Unsigned binary value, at most 9999800001 |
| bcd_vld | output | 1 | Marks `bcd_val` as a finished conversion |
| bcd_val | output | 40 | Ten packed BCD digits, units digit in bits 3:0 |

## Verification
The bench aims at inputs where a radix-1000 digit rolls over: 999 against 1000, the millions boundary, the billions boundary and the maximum 9999800001. A slice that misses its final correction (remainder at least 1000) would leave a nibble group reading 1000 or more and an undercounted next digit. A wrong fold width would corrupt only large values, so the bench mixes random values up to the maximum with an exhaustive sweep of 0..3000. A miscounted pipeline depth or a lost valid shows up in the latency test, the gapped stream and the reset-during-flight test, which count pulses and compare results in order.

// File: rtl/b1k_pkg.sv
// Package: shared digit types and the arithmetic kernels of the
// radix-1000 converter. Assumes every caller keeps inputs in the ranges
// named on each function.
package b1k_pkg;

    localparam int BIN_W    = 34;            // binary input width
    localparam int DIGITS   = 10;            // BCD digits produced
    localparam int BCD_W    = 4 * DIGITS;    // packed BCD width
    localparam int SLICE_W  = 20;            // widest residual a slice takes
    localparam int LOW_W    = 10;            // bits folded per step (2^10 = 1000 + 24)
    localparam int QUO_W    = SLICE_W - LOW_W + 1;

    typedef struct packed {
        logic [QUO_W-1:0] quo;
        logic [LOW_W-1:0] rem;
    } div1k_t;

    // Exact divide by 1000 of a value below 2^20: two folds, then one
    // conditional correction because the folded remainder stays below 2000.
    function automatic div1k_t div1000_20(input logic [SLICE_W-1:0] v);
        div1k_t          r;
        logic [9:0]      hi;
        logic [14:0]     c;
        logic [4:0]      h2;
        logic [10:0]     c2;
        logic [QUO_W-1:0] qe;
        hi = v[SLICE_W-1:LOW_W];
        c  = 15'({hi, 4'b0000}) + 15'({hi, 3'b000}) + 15'(v[LOW_W-1:0]);
        h2 = c[14:10];
        c2 = 11'({h2, 4'b0000}) + 11'({h2, 3'b000}) + 11'(c[9:0]);
        qe = QUO_W'(hi) + QUO_W'(h2);
        if (c2 >= 11'd1000) begin
            r.quo = qe + QUO_W'(1);
            r.rem = 10'(c2 - 11'd1000);
        end else begin
            r.quo = qe;
            r.rem = c2[9:0];
        end
        return r;
    endfunction

    // Expand a value 0..999 into three BCD nibbles with the add-3 rule.
    function automatic logic [11:0] bin10_to_bcd3(input logic [9:0] v);
        logic [21:0] s;
        s = {12'd0, v};
        for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 3; j++) begin
                if (s[10+4*j +: 4] >= 4'd5)
                    s[10+4*j +: 4] = s[10+4*j +: 4] + 4'd3;
            end
            s = s << 1;
        end
        return s[21:10];
    endfunction

endpackage

// File: rtl/b1k_fold.sv
// Module: one registered fold step. Splits the residual at bit 10 and
// rewrites it as 24*hi + lo, while adding hi (the count of thousands
// moved out) to the running accumulator.
// Assumes: RES_W > 10 and the caller sizes OUT_W and ACC_W to the range
// of values that actually arrive.
module b1k_fold #(
    parameter int RES_W = 34,
    parameter int OUT_W = 28,
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [RES_W-1:0] in_res,
    input  logic [ACC_W-1:0] in_acc,
    output logic             out_vld,
    output logic [OUT_W-1:0] out_res,
    output logic [ACC_W-1:0] out_acc
);
    localparam int HI_W = RES_W - 10;

    logic [HI_W-1:0]  hi;
    logic [OUT_W-1:0] hi_w;
    logic [OUT_W-1:0] res_n;
    logic [ACC_W-1:0] acc_n;

    // Fold arithmetic: 24*hi built as 16*hi + 8*hi, plus the low ten bits.
    always_comb begin
        hi    = in_res[RES_W-1:10];
        hi_w  = OUT_W'(hi);
        res_n = (hi_w << 4) + (hi_w << 3) + OUT_W'(in_res[9:0]);
        acc_n = in_acc + ACC_W'(hi);
    end

    // Stage register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_res <= '0;
            out_acc <= '0;
        end else begin
            out_vld <= in_vld;
            out_res <= res_n;
            out_acc <= acc_n;
        end
    end
endmodule

// File: rtl/b1k_slice.sv
// Module: one registered radix-1000 slice. Divides a residual of at most
// 20 bits by 1000 exactly, emits the remainder as a digit and adds the
// quotient to the accumulator of thousands.
// Assumes: RES_W <= 20.
module b1k_slice
    import b1k_pkg::*;
#(
    parameter int RES_W = 18,
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [RES_W-1:0] in_res,
    input  logic [ACC_W-1:0] in_acc,
    output logic             out_vld,
    output logic [9:0]       out_dig,
    output logic [ACC_W-1:0] out_acc
);
    div1k_t qr;

    // Exact divide-by-1000 of the widened residual.
    always_comb qr = div1000_20(SLICE_W'(in_res));

    // Stage register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_dig <= '0;
            out_acc <= '0;
        end else begin
            out_vld <= in_vld;
            out_dig <= qr.rem;
            out_acc <= in_acc + ACC_W'(qr.quo);
        end
    end
endmodule

// File: rtl/b1k_bin2bcd.sv
// Module: top of the converter. Eight register stages:
//   1-3 fold the input toward 20 bits, 4 slices off d0,
//   5 folds the thousands count, 6 slices off d1,
//   7 splits the rest into d2 and d3, 8 expands to BCD.
// Assumes: bin_val <= 9999800001, so d3 fits one nibble (R2, R6).
module b1k_bin2bcd
    import b1k_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bin_vld,
    input  logic [BIN_W-1:0]   bin_val,
    output logic               bcd_vld,
    output logic [BCD_W-1:0]   bcd_val
);
    // Widths follow the bounds of each stage for inputs in range.
    localparam int R1_W = 28;  // after first fold
    localparam int R2_W = 23;  // after second fold
    localparam int R3_W = 18;  // after third fold
    localparam int A0_W = 24;  // thousands of the input
    localparam int A1_W = 14;  // millions of the input
    localparam int A2_W = 4;   // billions digit

    logic            v1, v2, v3, v4, v5, v6, v7;
    logic [R1_W-1:0] r1;
    logic [R2_W-1:0] r2;
    logic [R3_W-1:0] r3, r5;
    logic [A0_W-1:0] a1, a2, a3, a4;
    logic [A1_W-1:0] a5, a6;
    logic [A2_W-1:0] a7;
    logic [9:0]      d0_s4, d1_s6, d2_s7;
    logic [9:0]      d0_s5, d0_s6, d0_s7, d1_s7;

    b1k_fold #(.RES_W(BIN_W), .OUT_W(R1_W), .ACC_W(A0_W)) u_fold1 (
        .clk(clk), .rst_n(rst_n), .in_vld(bin_vld), .in_res(bin_val),
        .in_acc('0), .out_vld(v1), .out_res(r1), .out_acc(a1));

    b1k_fold #(.RES_W(R1_W), .OUT_W(R2_W), .ACC_W(A0_W)) u_fold2 (
        .clk(clk), .rst_n(rst_n), .in_vld(v1), .in_res(r1),
        .in_acc(a1), .out_vld(v2), .out_res(r2), .out_acc(a2));

    b1k_fold #(.RES_W(R2_W), .OUT_W(R3_W), .ACC_W(A0_W)) u_fold3 (
        .clk(clk), .rst_n(rst_n), .in_vld(v2), .in_res(r2),
        .in_acc(a2), .out_vld(v3), .out_res(r3), .out_acc(a3));

    b1k_slice #(.RES_W(R3_W), .ACC_W(A0_W)) u_slice0 (
        .clk(clk), .rst_n(rst_n), .in_vld(v3), .in_res(r3),
        .in_acc(a3), .out_vld(v4), .out_dig(d0_s4), .out_acc(a4));

    b1k_fold #(.RES_W(A0_W), .OUT_W(R3_W), .ACC_W(A1_W)) u_fold4 (
        .clk(clk), .rst_n(rst_n), .in_vld(v4), .in_res(a4),
        .in_acc('0), .out_vld(v5), .out_res(r5), .out_acc(a5));

    b1k_slice #(.RES_W(R3_W), .ACC_W(A1_W)) u_slice1 (
        .clk(clk), .rst_n(rst_n), .in_vld(v5), .in_res(r5),
        .in_acc(a5), .out_vld(v6), .out_dig(d1_s6), .out_acc(a6));

    b1k_slice #(.RES_W(A1_W), .ACC_W(A2_W)) u_slice2 (
        .clk(clk), .rst_n(rst_n), .in_vld(v6), .in_res(a6),
        .in_acc('0), .out_vld(v7), .out_dig(d2_s7), .out_acc(a7));

    // Delay the early digits so all four line up at stage 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d0_s5 <= '0;
            d0_s6 <= '0;
            d0_s7 <= '0;
            d1_s7 <= '0;
        end else begin
            d0_s5 <= d0_s4;
            d0_s6 <= d0_s5;
            d0_s7 <= d0_s6;
            d1_s7 <= d1_s6;
        end
    end

    // Final stage: add-3 expansion of each radix-1000 digit (R2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcd_vld <= 1'b0;
            bcd_val <= '0;
        end else begin
            bcd_vld <= v7;
            bcd_val <= {a7, bin10_to_bcd3(d2_s7),
                        bin10_to_bcd3(d1_s7), bin10_to_bcd3(d0_s7)};
        end
    end
endmodule

// File: rtl/b1k_bin2bcd_chk.sv
// Module: assertion checker bound to the converter top. Holds a decimal
// reference model and a cycles-since-reset counter that gates the
// eight-deep look-back.
module b1k_bin2bcd_chk
    import b1k_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bin_vld,
    input logic [BIN_W-1:0] bin_val,
    input logic             bcd_vld,
    input logic [BCD_W-1:0] bcd_val
);
    localparam int LAT = 8;

    logic [3:0] run_cnt;
    logic       rst_q;

    // Count rising edges seen with reset released, saturating at LAT.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_cnt <= '0;
        else if (run_cnt < 4'(LAT))  run_cnt <= run_cnt + 4'd1;
    end

    // Remember the reset level of the previous edge.
    always_ff @(posedge clk) rst_q <= rst_n;

    function automatic logic [BCD_W-1:0] dec_model(input logic [BIN_W-1:0] v);
        logic [BCD_W-1:0]  r;
        longint unsigned   t;
        t = longint'(v);
        for (int i = 0; i < DIGITS; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic logic all_dec(input logic [BCD_W-1:0] b);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++)
            if (b[4*i +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    // Outputs cleared one cycle after a reset edge.
    always @(posedge clk) begin
        if (rst_q === 1'b0)
            AST_RESET_CLEARS: assert (bcd_vld == 1'b0 && bcd_val == '0); // R1
    end

    AST_VALUE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 4'(LAT) && bcd_vld) |-> bcd_val == dec_model($past(bin_val, 8))); // R2

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 4'(LAT)) |-> bcd_vld == $past(bin_vld, 8)); // R3

    AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_vld |-> all_dec(bcd_val)); // R6

endmodule

bind b1k_bin2bcd b1k_bin2bcd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bin_vld(bin_vld), .bin_val(bin_val),
    .bcd_vld(bcd_vld), .bcd_val(bcd_val)
);

// File: tb/b1k_bin2bcd_tb_top.sv
// Bench: vector table, exhaustive low range, random stream, then
// directed reset, latency, gap and reset-in-flight tests.
module b1k_bin2bcd_tb_top;
    localparam longint unsigned VMAX = 64'd9999800001;
    localparam int NVEC = 12;
    // {value, expected BCD}; a BCD pattern reads as the decimal value in hex.
    localparam logic [73:0] VEC [NVEC] = '{
        {34'd0,          40'h0000000000},
        {34'd999,        40'h0000000999},
        {34'd1000,       40'h0000001000},
        {34'd1023,       40'h0000001023},
        {34'd1024,       40'h0000001024},
        {34'd999999,     40'h0000999999},
        {34'd1000000,    40'h0001000000},
        {34'd999999999,  40'h0999999999},
        {34'd1000000000, 40'h1000000000},
        {34'd9999800001, 40'h9999800001},
        {34'd8589934591, 40'h8589934591},
        {34'd1234567890, 40'h1234567890}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bin_vld = 1'b0;
    logic [33:0] bin_val = '0;
    logic        bcd_vld;
    logic [39:0] bcd_val;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int pulses = 0;
    logic [39:0] exp_q[$];
    string       tag_q[$];

    b1k_bin2bcd dut_i (.clk(clk), .rst_n(rst_n), .bin_vld(bin_vld),
                       .bin_val(bin_val), .bcd_vld(bcd_vld), .bcd_val(bcd_val));

    always #5 clk = ~clk;

    function automatic logic [39:0] dec_ref(input longint unsigned v);
        logic [39:0] r;
        for (int i = 0; i < 10; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Result monitor: compares every valid output in order.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && bcd_vld) begin
            pulses++;
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R5: unexpected result %h expected none", bcd_val);
            end else begin
                check(tag_q.pop_front(), bcd_val, exp_q.pop_front());
            end
        end
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: cycle %0d expected < 100000", cyc);
            finish_run();
        end
    end

    task automatic send(input longint unsigned v, input logic [39:0] exp, input string tag);
        @(negedge clk);
        bin_vld = 1'b1;
        bin_val = 34'(v);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bin_vld = 1'b0;
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 vld", {39'd0, bcd_vld}, 40'd0);
        check("R1 val", bcd_val, 40'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R7/R8: table of vectors, back to back
        for (int i = 0; i < NVEC; i++)
            send(longint'(VEC[i][73:40]), VEC[i][39:0],
                 (VEC[i][73:40] == 34'd9999800001) ? "R7 max" : "R8 table");
        idle(12);

        // R2/R4: exhaustive low range, back to back
        for (int v = 0; v <= 3000; v++)
            send(longint'(v), dec_ref(longint'(v)), "R4 sweep");
        idle(12);

        // R2: random values across the full range
        for (int i = 0; i < 3000; i++) begin
            longint unsigned rv;
            rv = {32'($urandom), 32'($urandom)} % (VMAX + 1);
            send(rv, dec_ref(rv), "R2 random");
        end
        idle(12);

        // R3: latency of a single input
        begin
            int wait_n;
            send(64'd424242, 40'h0000424242, "R3 value");
            @(negedge clk);
            bin_vld = 1'b0;
            wait_n = 1;
            while (!bcd_vld && wait_n < 20) begin
                @(negedge clk);
                wait_n++;
            end
            check("R3 latency", 40'(wait_n), 40'd8);
        end
        idle(12);

        // R5: gapped stream, pulses counted
        begin
            int p0;
            p0 = pulses;
            for (int i = 0; i < 20; i++) begin
                send(longint'(i * 777777), dec_ref(longint'(i * 777777)), "R5 gapped");
                idle(1 + (i % 3));
            end
            idle(12);
            check("R5 pulses", 40'(pulses - p0), 40'd20);
            check("R5 drained", 40'(exp_q.size()), 40'd0);
        end

        // R9: reset with conversions in flight
        begin
            int p0;
            for (int i = 0; i < 4; i++)
                send(64'd5555555555, 40'h5555555555, "R9 flushed");
            @(negedge clk);
            bin_vld = 1'b0;
            rst_n = 1'b0;
            exp_q.delete();
            tag_q.delete();
            @(negedge clk);
            check("R9 cleared", {39'd0, bcd_vld}, 40'd0);
            rst_n = 1'b1;
            p0 = pulses;
            idle(12);
            check("R9 no pulses", 40'(pulses - p0), 40'd0);
            send(64'd1000001, 40'h0001000001, "R9 resumed");
            idle(12);
        end

        finish_run();
    end
endmodule